// File: doc/BRIEF.md
# Four-Channel Triggered DMA Engine

This block moves data between memory locations on behalf of a processor. It has four channels. Each one holds a programmed source address, destination address, unit count and control word. Software writes these through a narrow configuration port. Setting a channel's enable bit copies the programmed values into the channel's working registers.

Each channel starts in one of three ways:
- at once, when it is enabled;
- on the next horizontal-blank pulse;
- on the next vertical-blank pulse.

Once started, the channel is armed. An armed and enabled channel is stepped one unit at a time over a single memory port. Each step is one read at the working source address, then one write of that data to the working destination address. After the step, the addresses move and the count drops by one.

At terminal count there are two outcomes:
- A one-shot channel clears its enable bit and can raise a one-cycle interrupt.
- A repeating channel stays enabled but disarms. It waits for its next blanking pulse, which reloads its count and, in one address mode, its destination.

A fixed-priority selector serves one channel per step. It raises a stall output to the processor while a channel that started at once is being stepped.

Top module: `dmx_engine`

## Requirements
- R1: After reset the memory port is idle (`mem_req` low), `cpu_stall` is low, all `irq` bits are low and all `chan_on` bits are low.
- R2: A configuration write to field 3 (control) with bit 9 (enable) set, while the channel's enable is clear, copies the programmed source (field 0), destination (field 1) and count (field 2) into the working registers. A programmed count of 0 loads the maximum count instead: 16383 for channels 0 to 2 (14-bit count) and 65535 for channel 3 (16-bit count).
- R3: Control bits [7:6] select the start mode: 00 arms the channel when it is enabled, 01 waits for a `vblank` pulse and 10 waits for an `hblank` pulse. A channel waiting for one kind of pulse ignores the other kind.
- R4: A step is one read at the working source address, followed by one write to the working destination address carrying the data returned by that read. `mem_word` follows control bit 5 (1 = 32-bit unit, 0 = halfword unit).
- R5: Control bits [3:2] set the source mode and bits [1:0] set the destination mode. The codes are: 0 increment, 1 decrement, 2 fixed, 3 increment with reload. The step size is 4 for 32-bit units and 2 for halfwords, and addresses wrap modulo 2^32. Source code 3 is illegal and leaves the source address unchanged.
- R6: When the working count reaches zero and repeat (bit 4) is clear, the channel clears its `chan_on` bit. If interrupt enable (bit 8) is set, it also pulses its `irq` bit for exactly one cycle.
- R7: When a repeating channel reaches zero, it stays enabled and stops stepping until its next matching blanking pulse. That pulse reloads the working count from the programmed count and, in destination mode 3, reloads the working destination from the programmed destination.
- R8: A blanking pulse that reaches an already armed channel has no effect on its count or addresses.
- R9: Only one step is in progress at a time. When several channels are ready, channel 0 wins, then 1, then 2, then 3.
- R10: `cpu_stall` is high exactly during the memory cycles of a step for a channel in start mode 00, and never for a blanking-started channel.
- R11: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel selected by the write |
| cfg_field | input | 2 | Field: 0 source, 1 destination, 2 count, 3 control |
| cfg_data | input | 32 | Write data |
| hblank | input | 1 | Horizontal-blank pulse, one cycle |
| vblank | input | 1 | Vertical-blank pulse, one cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = 32-bit unit, 0 = halfword |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory handshake acknowledge |
| cpu_stall | output | 1 | Processor must stall |
| chan_on | output | 4 | Enable bit of each channel |
| irq | output | 4 | Per-channel terminal-count pulse |

## Verification
The data path is tried with word and halfword units under each pairing of increment, decrement, fixed and reload modes. Each pattern is chosen so that a wrong step size, sign or hold shows up as a distinct address sequence. A decrement across address zero separates modular wrap from saturation. A zero programmed count run to the end separates a maximum-count load from an immediate stop.

The start modes are tried with the wrong pulse, the right pulse and a second pulse, which tells arming apart from reloading. A pulse that arrives mid-run shows whether an armed channel is wrongly reloaded. Two channels armed by the same pulse expose the priority order. A memory that acknowledges only every other cycle shows whether requests are held steady.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [1:0] {
        TIM_NOW = 2'b00,
        TIM_VBL = 2'b01,
        TIM_HBL = 2'b10,
        TIM_SPC = 2'b11
    } timing_e;

    typedef enum logic [1:0] {
        ADJ_INC     = 2'b00,
        ADJ_DEC     = 2'b01,
        ADJ_FIX     = 2'b10,
        ADJ_INC_RLD = 2'b11
    } adj_e;

    typedef enum logic [1:0] {
        FLD_SRC = 2'd0,
        FLD_DST = 2'd1,
        FLD_CNT = 2'd2,
        FLD_CTL = 2'd3
    } field_e;

    // control word, bit 9 down to bit 0
    typedef struct packed {
        logic    enable;
        logic    irq_en;
        timing_e timing;
        logic    word;
        logic    repeat_on;
        adj_e    src_adj;
        adj_e    dst_adj;
    } ctrl_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

endpackage

// File: rtl/dmx_prio.sv
module dmx_prio #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest index wins
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dmx_chan.sv
module dmx_chan
    import dmx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  field_e            cfg_field,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              step_done,
    output logic              ready,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              word,
    output logic              immediate,
    output logic              enabled,
    output logic              irq
);
    localparam int CTL_W = $bits(ctrl_t);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        ctrl_t             ctl;
        logic              armed;
        logic              irq;
        logic [ADDR_W-1:0] src_prog;
        logic [ADDR_W-1:0] dst_prog;
        logic [ADDR_W-1:0] src_work;
        logic [ADDR_W-1:0] dst_work;
        logic [CNT_W-1:0]  cnt_prog;
        logic [CNT_W-1:0]  cnt_work;
    } chan_t;

    chan_t q, d;
    logic [CNT_W-1:0]  cnt_load;
    logic [ADDR_W-1:0] delta;
    ctrl_t             ctl_new;
    logic              pulse_hit;

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        cnt_load  = (q.cnt_prog == '0) ? CNT_MAX : q.cnt_prog;
        delta     = q.ctl.word ? ADDR_W'(4) : ADDR_W'(2);
        ctl_new   = ctrl_t'(cfg_data[CTL_W-1:0]);
        pulse_hit = !q.armed && q.ctl.enable &&
                    ((hblank && q.ctl.timing == TIM_HBL) ||
                     (vblank && q.ctl.timing == TIM_VBL));

        if (step_done) begin
            case (q.ctl.src_adj)
                ADJ_INC: d.src_work = q.src_work + delta;
                ADJ_DEC: d.src_work = q.src_work - delta;
                default: d.src_work = q.src_work;
            endcase
            case (q.ctl.dst_adj)
                ADJ_INC, ADJ_INC_RLD: d.dst_work = q.dst_work + delta;
                ADJ_DEC:              d.dst_work = q.dst_work - delta;
                default:              d.dst_work = q.dst_work;
            endcase
            d.cnt_work = q.cnt_work - CNT_W'(1);
            if (q.cnt_work == CNT_W'(1)) begin
                d.armed = 1'b0;
                if (!q.ctl.repeat_on) begin
                    d.ctl.enable = 1'b0;
                    d.irq        = q.ctl.irq_en;
                end
            end
        end

        if (pulse_hit) begin
            d.armed = 1'b1;
            if (q.ctl.repeat_on) begin
                d.cnt_work = cnt_load;
                if (q.ctl.dst_adj == ADJ_INC_RLD) d.dst_work = q.dst_prog;
            end
        end

        if (cfg_we) begin
            case (cfg_field)
                FLD_SRC: d.src_prog = cfg_data;
                FLD_DST: d.dst_prog = cfg_data;
                FLD_CNT: d.cnt_prog = cfg_data[CNT_W-1:0];
                default: begin
                    d.ctl = ctl_new;
                    if (ctl_new.enable && !q.ctl.enable) begin
                        d.src_work = q.src_prog;
                        d.dst_work = q.dst_prog;
                        d.cnt_work = cnt_load;
                        d.armed    = (ctl_new.timing == TIM_NOW);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready     = q.ctl.enable && q.armed;
    assign src_addr  = q.src_work;
    assign dst_addr  = q.dst_work;
    assign word      = q.ctl.word;
    assign immediate = (q.ctl.timing == TIM_NOW);
    assign enabled   = q.ctl.enable;
    assign irq       = q.irq;
endmodule

// File: rtl/dmx_engine.sv
module dmx_engine
    import dmx_pkg::*;
#(
    parameter  int ADDR_W   = 32,
    parameter  int DATA_W   = 32,
    parameter  int NCH      = 4,
    parameter  int CNT_W_LO = 14,
    parameter  int CNT_W_HI = 16,
    localparam int CH_W     = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              hblank,
    input  logic              vblank,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              cpu_stall,
    output logic [NCH-1:0]    chan_on,
    output logic [NCH-1:0]    irq
);
    typedef struct packed {
        phase_e            phase;
        logic [CH_W-1:0]   ch;
        logic [DATA_W-1:0] data;
    } eng_t;

    eng_t q, d;

    logic [NCH-1:0]             ready_all;
    logic [NCH-1:0]             word_all;
    logic [NCH-1:0]             imm_all;
    logic [NCH-1:0][ADDR_W-1:0] src_all;
    logic [NCH-1:0][ADDR_W-1:0] dst_all;
    logic                       any_ready;
    logic [CH_W-1:0]            grant;
    logic                       step_done;

    assign step_done = (q.phase == PH_WRITE) && mem_ack;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int CW = (c == NCH - 1) ? CNT_W_HI : CNT_W_LO;
        dmx_chan #(
            .ADDR_W(ADDR_W),
            .CNT_W (CW)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we && (cfg_chan == CH_W'(c))),
            .cfg_field(field_e'(cfg_field)),
            .cfg_data (cfg_data),
            .hblank   (hblank),
            .vblank   (vblank),
            .step_done(step_done && (q.ch == CH_W'(c))),
            .ready    (ready_all[c]),
            .src_addr (src_all[c]),
            .dst_addr (dst_all[c]),
            .word     (word_all[c]),
            .immediate(imm_all[c]),
            .enabled  (chan_on[c]),
            .irq      (irq[c])
        );
    end

    dmx_prio #(.N(NCH), .IW(CH_W)) u_prio (
        .req(ready_all),
        .any(any_ready),
        .idx(grant)
    );

    always_comb begin
        d = q;
        case (q.phase)
            PH_IDLE: begin
                if (any_ready) begin
                    d.ch    = grant;
                    d.phase = PH_READ;
                end
            end
            PH_READ: begin
                if (mem_ack) begin
                    d.data  = mem_rdata;
                    d.phase = PH_WRITE;
                end
            end
            PH_WRITE: begin
                if (mem_ack) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req   = (q.phase != PH_IDLE);
    assign mem_we    = (q.phase == PH_WRITE);
    assign mem_addr  = (q.phase == PH_WRITE) ? dst_all[q.ch] : src_all[q.ch];
    assign mem_word  = word_all[q.ch];
    assign mem_wdata = q.data;
    assign cpu_stall = mem_req && imm_all[q.ch];
endmodule

// File: rtl/dmx_engine_chk.sv
module dmx_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int NCH    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cpu_stall,
    input logic [NCH-1:0]    chan_on,
    input logic [NCH-1:0]    irq
);
    assert_stall_in_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> mem_req);

    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req && mem_we) |-> $past(mem_req && !mem_we && mem_ack));

    assert_hold_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |=> ((irq & $past(irq)) == '0));

    assert_irq_drops_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> ((irq & chan_on) == '0));
endmodule

bind dmx_engine dmx_engine_chk #(.ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .cpu_stall(cpu_stall),
    .chan_on  (chan_on),
    .irq      (irq)
);

// File: tb/dmx_engine_test.sv
`timescale 1ns/1ps
module dmx_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_chan = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_data = '0;
    logic        hblank = 1'b0;
    logic        vblank = 1'b0;
    logic        mem_req, mem_we, mem_word, mem_ack, cpu_stall;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  chan_on, irq;
    logic        slow = 1'b0;
    logic        ack_en = 1'b1;

    localparam logic [31:0] KEY = 32'h5A5A_0000;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem_addr ^ KEY;
    assign mem_ack   = mem_req && ack_en;

    dmx_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .hblank(hblank), .vblank(vblank),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .cpu_stall(cpu_stall), .chan_on(chan_on), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int nw = 0;
    int nr = 0;
    int stall_cnt = 0;
    int irq_cnt [4] = '{0, 0, 0, 0};
    logic [31:0] wa [1024];
    logic [31:0] wd [1024];
    logic        ws [1024];
    logic [31:0] ra [1024];

    always @(posedge clk) begin
        ack_en <= slow ? ~ack_en : 1'b1;
        if (cpu_stall) stall_cnt <= stall_cnt + 1;
        for (int i = 0; i < 4; i++) if (irq[i]) irq_cnt[i] <= irq_cnt[i] + 1;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                if (nw < 1024) begin
                    wa[nw] <= mem_addr; wd[nw] <= mem_wdata; ws[nw] <= mem_word;
                end
                nw <= nw + 1;
            end else begin
                if (nr < 1024) ra[nr] <= mem_addr;
                nr <= nr + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input bit ie, input logic [1:0] tim,
                                       input bit wd32, input bit rpt,
                                       input logic [1:0] sadj, input logic [1:0] dadj);
        return {22'd0, en, ie, tim, wd32, rpt, sadj, dadj};
    endfunction

    task automatic cfg(input int ch, input int fld, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_field = 2'(fld); cfg_data = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] t,
                         input logic [31:0] n, input logic [31:0] ctl);
        cfg(ch, 0, s); cfg(ch, 1, t); cfg(ch, 2, n); cfg(ch, 3, ctl);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit h);
        @(negedge clk);
        if (h) hblank = 1'b1; else vblank = 1'b1;
        @(negedge clk);
        hblank = 1'b0; vblank = 1'b0;
    endtask

    task automatic t_reset;
        chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 0);
        chk(cpu_stall == 1'b0, "R1", "cpu_stall", 32'(cpu_stall), 0);
        chk(irq == 4'd0, "R1", "irq", 32'(irq), 0);
        chk(chan_on == 4'd0, "R1", "chan_on", 32'(chan_on), 0);
    endtask

    task automatic t_immediate;
        int b = nw; int s0 = stall_cnt; int i0 = irq_cnt[1];
        setup(1, 32'h100, 32'h200, 3, mk(1, 1, 2'b00, 1, 0, 2'd0, 2'd0));
        idle(20);
        chk(nw - b == 3, "R2", "write count", 32'(nw - b), 3);
        for (int k = 0; k < 3; k++) begin
            chk(ra[b+k] == 32'h100 + 32'(4*k), "R5", "read addr", ra[b+k], 32'h100 + 32'(4*k));
            chk(wa[b+k] == 32'h200 + 32'(4*k), "R5", "write addr", wa[b+k], 32'h200 + 32'(4*k));
            chk(wd[b+k] == ((32'h100 + 32'(4*k)) ^ KEY), "R4", "write data", wd[b+k],
                (32'h100 + 32'(4*k)) ^ KEY);
            chk(ws[b+k] == 1'b1, "R4", "unit size", 32'(ws[b+k]), 1);
        end
        chk(chan_on[1] == 1'b0, "R6", "enable cleared", 32'(chan_on[1]), 0);
        chk(irq_cnt[1] - i0 == 1, "R6", "irq pulses", 32'(irq_cnt[1] - i0), 1);
        chk(stall_cnt - s0 == 6, "R10", "stall cycles", 32'(stall_cnt - s0), 6);
    endtask

    task automatic t_modes;
        int b = nw; int i0 = irq_cnt[2];
        // halfword, source decrement across zero, fixed destination
        setup(2, 32'h2, 32'h300, 3, mk(1, 0, 2'b00, 0, 0, 2'd1, 2'd2));
        idle(20);
        chk(nw - b == 3, "R5", "write count", 32'(nw - b), 3);
        chk(ra[b] == 32'h2, "R5", "dec read 0", ra[b], 32'h2);
        chk(ra[b+1] == 32'h0, "R5", "dec read 1", ra[b+1], 32'h0);
        chk(ra[b+2] == 32'hFFFF_FFFE, "R5", "wrap read", ra[b+2], 32'hFFFF_FFFE);
        chk(wa[b+2] == 32'h300, "R5", "fixed dst", wa[b+2], 32'h300);
        chk(ws[b] == 1'b0, "R4", "halfword size", 32'(ws[b]), 0);
        chk(chan_on[2] == 1'b0, "R6", "enable cleared", 32'(chan_on[2]), 0);
        chk(irq_cnt[2] == i0, "R6", "no irq when disabled", 32'(irq_cnt[2] - i0), 0);
        // illegal source code 3 holds, destination decrements by 4
        b = nw;
        setup(0, 32'h40, 32'h80, 2, mk(1, 0, 2'b00, 1, 0, 2'd3, 2'd1));
        idle(15);
        chk(ra[b+1] == 32'h40, "R5", "src code 3 holds", ra[b+1], 32'h40);
        chk(wa[b+1] == 32'h7C, "R5", "dst decrement", wa[b+1], 32'h7C);
    endtask

    task automatic t_hblank_repeat;
        int b = nw; int s0 = stall_cnt; int i0 = irq_cnt[2];
        setup(2, 32'h400, 32'h500, 2, mk(1, 1, 2'b10, 1, 1, 2'd0, 2'd3));
        idle(10);
        chk(nw - b == 0, "R3", "no start before pulse", 32'(nw - b), 0);
        pulse(1'b0);
        idle(10);
        chk(nw - b == 0, "R3", "vblank ignored", 32'(nw - b), 0);
        pulse(1'b1);
        idle(12);
        chk(nw - b == 2, "R3", "hblank starts", 32'(nw - b), 2);
        chk(wa[b+1] == 32'h504, "R5", "dst second", wa[b+1], 32'h504);
        chk(chan_on[2] == 1'b1, "R7", "repeat stays on", 32'(chan_on[2]), 1);
        chk(irq_cnt[2] == i0, "R7", "repeat no irq", 32'(irq_cnt[2] - i0), 0);
        idle(10);
        chk(nw - b == 2, "R7", "disarmed after run", 32'(nw - b), 2);
        pulse(1'b1);
        idle(12);
        chk(nw - b == 4, "R7", "count reloaded", 32'(nw - b), 4);
        chk(wa[b+2] == 32'h500, "R7", "dst reloaded", wa[b+2], 32'h500);
        chk(ra[b+2] == 32'h408, "R7", "src continues", ra[b+2], 32'h408);
        chk(stall_cnt == s0, "R10", "no stall for blank channel", 32'(stall_cnt - s0), 0);
        cfg(2, 3, 32'h0);
    endtask

    task automatic t_priority;
        int b = nw;
        setup(3, 32'h3000, 32'h4000, 2, mk(1, 0, 2'b01, 1, 0, 2'd0, 2'd0));
        setup(0, 32'h1000, 32'h2000, 2, mk(1, 0, 2'b01, 1, 0, 2'd0, 2'd0));
        pulse(1'b0);
        idle(20);
        chk(nw - b == 4, "R9", "both ran", 32'(nw - b), 4);
        chk(wa[b] == 32'h2000, "R9", "ch0 first", wa[b], 32'h2000);
        chk(wa[b+1] == 32'h2004, "R9", "ch0 second", wa[b+1], 32'h2004);
        chk(wa[b+2] == 32'h4000, "R9", "ch3 after", wa[b+2], 32'h4000);
    endtask

    task automatic t_armed_pulse;
        int b = nw;
        setup(3, 32'h5000, 32'h6000, 4, mk(1, 0, 2'b01, 1, 1, 2'd0, 2'd3));
        pulse(1'b0);
        idle(4);
        pulse(1'b0);
        idle(30);
        chk(nw - b == 4, "R8", "no extra steps", 32'(nw - b), 4);
        chk(wa[b+3] == 32'h600C, "R8", "dst not reloaded", wa[b+3], 32'h600C);
        chk(chan_on[3] == 1'b1, "R7", "repeat stays on", 32'(chan_on[3]), 1);
        cfg(3, 3, 32'h0);
    endtask

    task automatic t_slow_ack;
        int b = nw;
        slow = 1'b1;
        setup(1, 32'h700, 32'h780, 2, mk(1, 0, 2'b00, 1, 0, 2'd0, 2'd0));
        idle(30);
        slow = 1'b0;
        chk(nw - b == 2, "R11", "writes with slow ack", 32'(nw - b), 2);
        chk(wd[b+1] == (32'h704 ^ KEY), "R11", "data with slow ack", wd[b+1], 32'h704 ^ KEY);
        chk(wa[b+1] == 32'h784, "R11", "addr with slow ack", wa[b+1], 32'h784);
    endtask

    task automatic t_max_count;
        int b = nw; int i0 = irq_cnt[0]; int w = 0;
        setup(0, 32'h0, 32'h10000, 0, mk(1, 1, 2'b00, 1, 0, 2'd2, 2'd2));
        while (irq_cnt[0] == i0 && w < 60000) begin
            @(negedge clk);
            w++;
        end
        idle(4);
        chk(nw - b == 16383, "R2", "zero count loads max", 32'(nw - b), 16383);
        chk(chan_on[0] == 1'b0, "R6", "enable cleared at max", 32'(chan_on[0]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_immediate();
        t_modes();
        t_hblank_repeat();
        t_priority();
        t_armed_pulse();
        t_slow_ack();
        t_max_count();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule